// File: doc/BRIEF.md
# Token-Ring Sparse Readout Multiplexer

This block collects hit entries from a large set of per-channel queues and puts them, one per clock, onto a single shared output bus. Each queue reports whether it holds an entry and shows the entry at its head. A token walks around the ring of channels. Only the channel chosen by the token hands its head entry to the output. Empty channels are passed over in the same cycle, so no output slot is wasted on them. A channel that keeps refilling is revisited on every pass of the token, which spreads the output bandwidth towards the channels that actually have data.

Every output word carries the number of the channel it came from. Downstream logic uses that number as the spatial coordinate of the hit. The output register uses a valid/ready handshake. The queues see a one-hot `ch_pop` pulse in the cycle in which their head entry is captured, and they advance their head at the next rising edge.

Top module: `tokring_readout_mux`

## Requirements
- R1: While reset is applied and after it is released, `out_valid` is low and `ch_pop` is all zero until at least one `ch_valid` bit is high.
- R2: At most one bit of `ch_pop` is high in any cycle, and no bit is high while `out_valid` is high and `out_ready` is low.
- R3: `out_word` holds the channel number in bits [22:16] and, in bits [15:0], the payload that this channel showed on `ch_data[ch*16 +: 16]` in its pop cycle.
- R4: A channel whose `ch_valid` is low is never popped and never appears in `out_word`.
- R5: After serving channel k, the next channel served is the first channel with `ch_valid` high in the order k+1, k+2, … , 127, 0, … , k. Channel k itself is considered last.
- R6: When one channel alone holds data and `out_ready` stays high, that channel is served on consecutive cycles until its queue is empty.
- R7: While `out_valid` is high and `out_ready` is low, `out_word` and the token position hold their values and no entry is popped.
- R8: When all channels are empty, `out_valid` falls once the last word is accepted and the token stays put. A later load is served starting just above the last channel served.
- R9: With `out_ready` held high, a load of n entries leaves in n consecutive cycles with `out_valid` high, and `out_valid` is low in the cycle after.
- R10: The first search after reset starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| ch_valid | input | 128 | Per-channel flag: the queue holds at least one entry |
| ch_data | input | 2048 | Head payload of each queue, 16 bits per channel, channel c at [c*16 +: 16] |
| ch_pop | output | 128 | One-hot: the queue of this channel advances its head at the next edge |
| out_valid | output | 1 | `out_word` holds an entry |
| out_ready | input | 1 | The consumer accepts `out_word` at this edge |
| out_word | output | 23 | Channel number [22:16] and payload [15:0] |

## Verification
The multiplexer is driven with several loads. A sparse load with a few busy channels on both sides of the wrap point tells apart a correct ascending search from one that restarts at zero or that revisits the last server too early. A single lone channel and a load of every channel with one entry show whether empty channels cost cycles and whether the block keeps one word per clock. Pseudo-random back-pressure on the dense and sparse loads checks that the word and the token are frozen during a stall and that no entry is lost or duplicated. A load given after an idle gap checks that the token did not drift while all queues were empty.

// File: rtl/tokmux_pkg.sv
package tokmux_pkg;
  localparam int DEF_CHANNELS  = 128;
  localparam int DEF_PAYLOAD_W = 16;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_state_e;
endpackage

// File: rtl/tokmux_rst_sync.sv
module tokmux_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tokmux_next_search.sv
// Finds the first requesting channel strictly above the token, wrapping
// round to the lowest requester; all in one combinational step.
module tokmux_next_search #(
  parameter int N  = 128,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [CW-1:0] tok,
  output logic [N-1:0]  gnt,
  output logic [CW-1:0] gnt_idx,
  output logic          any_req
);
  logic [N-1:0] above;
  logic [N-1:0] upper;
  logic [N-1:0] pick_vec;

  generate
    for (genvar g = 0; g < N; g++) begin : g_mask
      if (g == 0) begin : g_zero
        assign above[g] = 1'b0;
      end else begin : g_cmp
        assign above[g] = (tok < CW'(g));
      end
    end
  endgenerate

  function automatic logic [CW-1:0] encode(input logic [N-1:0] oh);
    logic [CW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) r = r | CW'(i);
    end
    return r;
  endfunction

  always_comb begin
    upper    = req & above;
    pick_vec = (|upper) ? upper : req;
    gnt      = pick_vec & (~pick_vec + N'(1));
    gnt_idx  = encode(gnt);
    any_req  = |req;
  end
endmodule

// File: rtl/tokmux_word_sel.sv
module tokmux_word_sel #(
  parameter int N  = 128,
  parameter int PW = 16
) (
  input  logic [N-1:0]    gnt,
  input  logic [N*PW-1:0] ch_data,
  output logic [PW-1:0]   payload
);
  logic [PW-1:0] masked [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_and
      assign masked[g] = ch_data[g*PW +: PW] & {PW{gnt[g]}};
    end
  endgenerate

  always_comb begin
    payload = '0;
    for (int i = 0; i < N; i++) payload = payload | masked[i];
  end
endmodule

// File: rtl/tokmux_out_stage.sv
module tokmux_out_stage
  import tokmux_pkg::*;
#(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         take,
  output logic         valid,
  output logic [W-1:0] dout
);
  slot_state_e  st_q, st_d;
  logic [W-1:0] data_q, data_d;
  logic         data_en;

  assign take    = (st_q == SLOT_EMPTY) || ready;
  assign data_en = take && fill;

  always_comb begin
    st_d   = st_q;
    data_d = data_q;
    if (take) begin
      st_d = fill ? SLOT_FULL : SLOT_EMPTY;
      if (fill) data_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= SLOT_EMPTY;
    else if (take) st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
  end

  assign valid = (st_q == SLOT_FULL);
  assign dout  = data_q;

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));

  // R9
  slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fill) |=> valid);
endmodule

// File: rtl/tokring_readout_mux.sv
module tokring_readout_mux
  import tokmux_pkg::*;
#(
  parameter int N_CH = DEF_CHANNELS,
  parameter int PW   = DEF_PAYLOAD_W,
  localparam int CW  = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int OW  = CW + PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   ch_valid,
  input  logic [N_CH*PW-1:0] ch_data,
  output logic [N_CH-1:0]   ch_pop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OW-1:0]     out_word
);
  logic            rst_n_s;
  logic [CW-1:0]   tok_q, tok_d;
  logic [N_CH-1:0] gnt;
  logic [CW-1:0]   gnt_idx;
  logic            any_req;
  logic [PW-1:0]   sel_payload;
  logic            take;
  logic            advance;

  tokmux_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  tokmux_next_search #(.N(N_CH)) u_search (
    .req     (ch_valid),
    .tok     (tok_q),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any_req (any_req)
  );

  tokmux_word_sel #(.N(N_CH), .PW(PW)) u_sel (
    .gnt     (gnt),
    .ch_data (ch_data),
    .payload (sel_payload)
  );

  tokmux_out_stage #(.W(OW)) u_out (
    .clk   (clk),
    .rst_n (rst_n_s),
    .fill  (any_req),
    .din   ({gnt_idx, sel_payload}),
    .ready (out_ready),
    .take  (take),
    .valid (out_valid),
    .dout  (out_word)
  );

  assign advance = take && any_req;
  assign ch_pop  = advance ? gnt : '0;

  always_comb begin
    tok_d = tok_q;
    if (advance) tok_d = gnt_idx;
  end

  // Token starts on the last channel so the first search begins at 0.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     tok_q <= CW'(N_CH - 1);
    else if (advance) tok_q <= tok_d;
  end

  // R2
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(ch_pop));

  // R2
  stall_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |-> (ch_pop == '0));

  // R4
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((ch_pop & ~ch_valid) == '0));

  // R7
  stall_token_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |=> $stable(tok_q));

  // R3
  tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |-> (out_word[OW-1:PW] == tok_q));

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((!out_valid || out_ready) && (ch_valid == '0)) |=> (!out_valid && $stable(tok_q)));
endmodule

// File: tb/test_tokring_readout_mux.sv
module test_tokring_readout_mux;
  localparam int  N_CH  = 128;
  localparam int  PW    = 16;
  localparam int  CW    = 7;
  localparam int  OW    = CW + PW;
  localparam time CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic              rst_n;
  logic [N_CH-1:0]   ch_valid;
  logic [N_CH-1:0]   ch_pop;
  logic [N_CH*PW-1:0] ch_data;
  logic              out_valid;
  logic              out_ready;
  logic [OW-1:0]     out_word;

  int main_checks, main_fails, mon_checks, mon_fails;
  int cnt [N_CH];
  int head [N_CH];
  int load_cnt [N_CH];
  int nxt_seq [N_CH];
  int plan [N_CH];
  bit load_req;
  int last_tok;
  int rdy_mode;
  logic [7:0] lfsr = 8'h5A;
  logic [OW-1:0] exp_q [$];
  bit stall_prev;
  logic [OW-1:0] stall_word;

  tokring_readout_mux #(.N_CH(N_CH), .PW(PW)) i_tokring_readout_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_valid  (ch_valid),
    .ch_data   (ch_data),
    .ch_pop    (ch_pop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
  );

  function automatic logic [PW-1:0] pay(input int ch, input int seq);
    return PW'(ch * 37 + seq * 11 + 4096);
  endfunction

  // queue model: head entry shown while non-empty
  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      ch_valid[i] = (cnt[i] > 0);
      ch_data[i*PW +: PW] = pay(i, head[i]);
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < N_CH; i++) begin
      cnt[i] <= cnt[i] - (ch_pop[i] ? 1 : 0) + (load_req ? load_cnt[i] : 0);
      if (ch_pop[i]) head[i] <= head[i] + 1;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) out_ready = 1'b1;
    else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[2];
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        mon_checks++;
        if (!(out_valid && out_word == stall_word)) begin
          mon_fails++;
          $display("FAIL R7 stall hold: valid=%0b word=%h expected %h", out_valid, out_word, stall_word);
        end
      end
      if (out_valid && !out_ready) begin
        mon_checks++;
        if (ch_pop != '0) begin
          mon_fails++;
          $display("FAIL R2 pop during stall: pop=%h expected 0", ch_pop);
        end
      end
      if (ch_pop != '0) begin
        mon_checks++;
        if ($countones(ch_pop) != 1 || (ch_pop & ~ch_valid) != '0) begin
          mon_fails++;
          $display("FAIL R4 pop=%h valid=%h expected one pop of a non-empty channel", ch_pop, ch_valid);
        end
      end
      if (out_valid && out_ready) begin
        mon_checks++;
        if (exp_q.size() == 0) begin
          mon_fails++;
          $display("FAIL R4 unexpected word %h expected none", out_word);
        end else begin
          logic [OW-1:0] e;
          e = exp_q.pop_front();
          if (out_word[OW-1:PW] != e[OW-1:PW]) begin
            mon_fails++;
            $display("FAIL R5 channel %0d expected %0d", out_word[OW-1:PW], e[OW-1:PW]);
          end else if (out_word[PW-1:0] != e[PW-1:0]) begin
            mon_fails++;
            $display("FAIL R3 payload %h expected %h", out_word[PW-1:0], e[PW-1:0]);
          end
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_word = out_word;
    end
  end

  task automatic main_check(input bit ok, input string req, input int act, input int expv);
    main_checks++;
    if (!ok) begin
      main_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: loads the queues and pushes the expected order (R5 walk)
  task automatic load_plan();
    int rem [N_CH];
    int total;
    int c;
    total = 0;
    for (int i = 0; i < N_CH; i++) begin
      rem[i] = plan[i];
      load_cnt[i] = plan[i];
      total += plan[i];
    end
    c = last_tok;
    for (int k = 0; k < total; k++) begin
      do c = (c + 1) % N_CH; while (rem[c] == 0);
      exp_q.push_back({CW'(c), pay(c, nxt_seq[c])});
      nxt_seq[c]++;
      rem[c]--;
    end
    if (total > 0) last_tok = c;
    @(negedge clk);
    load_req = 1'b1;
    @(posedge clk);
    #1 load_req = 1'b0;
  endtask

  task automatic clear_plan();
    for (int i = 0; i < N_CH; i++) plan[i] = 0;
  endtask

  task automatic drain(input string tag);
    for (int t = 0; t < 5000 && exp_q.size() != 0; t++) @(negedge clk);
    main_check(exp_q.size() == 0, {tag, " all words delivered"}, exp_q.size(), 0);
    repeat (3) @(negedge clk);
    main_check(!out_valid && ch_pop == '0, "R8 idle after drain", int'(out_valid), 0);
  endtask

  task automatic burst(input int n, input string tag);
    int seen;
    seen = 0;
    for (int t = 0; t < 20 && !out_valid; t++) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (out_valid && out_ready) seen++;
      @(negedge clk);
    end
    main_check(seen == n, tag, seen, n);
    main_check(!out_valid, "R9 valid low after burst", int'(out_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    load_req = 1'b0;
    rdy_mode = 0;
    last_tok = N_CH - 1;
    clear_plan();
    repeat (3) @(negedge clk);
    main_check(!out_valid && ch_pop == '0, "R1 in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    main_check(!out_valid && ch_pop == '0, "R1 after release", int'(out_valid), 0);

    // R10 R5: sparse load around the wrap point
    clear_plan();
    plan[0] = 1; plan[3] = 2; plan[40] = 1; plan[127] = 3;
    load_plan();
    drain("R10 R5 sparse");

    // R6: one lone busy channel
    clear_plan();
    plan[5] = 4;
    load_plan();
    burst(4, "R6 lone channel back-to-back");
    drain("R6 lone");

    // R7: sparse load with back-pressure
    rdy_mode = 1;
    clear_plan();
    plan[7] = 3; plan[8] = 1; plan[90] = 2; plan[126] = 2; plan[127] = 1;
    load_plan();
    drain("R7 stalled sparse");

    // R9: every channel one entry, full rate
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    clear_plan();
    for (int i = 0; i < N_CH; i++) plan[i] = 1;
    load_plan();
    burst(N_CH, "R9 dense one per clock");
    drain("R9 dense");

    // R8: idle gap, token must resume above last served channel
    repeat (6) @(negedge clk);
    main_check(!out_valid, "R8 idle gap", int'(out_valid), 0);
    rdy_mode = 1;
    clear_plan();
    plan[0] = 1; plan[64] = 2; plan[126] = 1;
    load_plan();
    drain("R8 resume");

    // R5 R7: uneven dense load with back-pressure
    clear_plan();
    for (int i = 0; i < N_CH; i++) plan[i] = i % 3;
    load_plan();
    drain("R5 uneven dense");

    rdy_mode = 0;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", main_checks + mon_checks, main_fails + mon_fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", main_checks + mon_checks + 1, main_fails + mon_fails + 1);
    $finish;
  end
endmodule